// File: doc/BRIEF.md
# Single-Wire Bus Slave with Address Layer

This block is the bottom of a single-wire bus slave. It watches the raw bus line and decides from low-pulse lengths whether the master sent a bus reset, a write slot or a read slot. It answers a bus reset with a presence pulse. It samples write slots and, in read slots, pulls the line low when it has a zero to return. The line is open-drain: the block never drives it high. It only raises `line_pull`, a pull-down enable. All timing counts whole microseconds from a tick divider, with two speed profiles chosen by a select pin.

Above the slot engine sits the address layer. After each bus reset it reads an 8-bit command. It then runs read-address, match, skip, search or resume against a 64-bit device address supplied on a port. The address is a family byte in bits 7:0, a 48-bit serial number and a check byte in bits 63:56. Once addressing succeeds, the block enters the function phase. Incoming bytes are handed to the next layer with a one-cycle strobe. Read slots return whatever bit that layer presents.

Top module: `ow_rom_slave`

## Requirements
- R1: A filtered low period of at least 120 µs (standard) or 16 µs (overdrive) is a bus reset. When it ends, the address layer returns to command reception, so `rom_done` is low from the next cycle on.
- R2: After a bus reset ends, the line stays released for 20 µs (standard) or 2 µs (overdrive). The block then pulls it low for 100 µs (standard) or 10 µs (overdrive) and releases it.
- R3: In a write slot the line is sampled 30 µs (standard) or 3 µs (overdrive) after the filtered falling edge. High is a 1 and low is a 0. Bits arrive LSb first.
- R4: In a read slot with a 0 to send, the block pulls the line low from the falling edge for 40 µs (standard) or 4 µs (overdrive). With a 1 it leaves the line released. The line is released again before the slot ends.
- R5: `speed_sel` is captured at the falling edge that starts each low period, and 1 selects overdrive. So a 20 µs low taken at standard speed is not a reset, but the same low taken at overdrive speed is.
- R6: The read-address command is 33h while `alt_read_op` is 0 and 39h while it is 1. It returns all 64 bits of `dev_addr`, bit 0 first, and then enters the function phase.
- R7: Command 55h compares the next 64 written bits against `dev_addr`, bit 0 first. On a full match the block enters the function phase. On any mismatch it ignores all traffic until the next bus reset: it produces no bytes and does not pull the line in read slots.
- R8: Command CCh enters the function phase directly.
- R9: Command F0h handles each address bit, from bit 0 up, in three slots. The block returns the bit, then returns its complement, then reads the master's bit. If that bit differs from its own, the block drops out until the next bus reset. After 64 agreeing bits it enters the function phase.
- R10: Command A5h enters the function phase only while the resume flag is set. A full match or search sets the flag, and a match mismatch or a search dropout clears it. Otherwise A5h is treated like an unknown command.
- R11: In the function phase, write-slot bits are packed LSb first into `rx_byte`, and `rx_valid` pulses for one cycle per byte. A slot that starts while `fn_tx_en` is high is a read slot. It returns `fn_tx_bit`, and `tx_ack` pulses once for it.
- R12: Before the first bus reset, and after an unknown command (33h while `alt_read_op` is 1, for example), the block leaves the line released and produces no bytes until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| line_in | input | 1 | Raw level of the bus line |
| speed_sel | input | 1 | 1 selects overdrive timing, 0 standard |
| alt_read_op | input | 1 | Selects 39h instead of 33h as the read-address command |
| dev_addr | input | 64 | Device address: family byte in 7:0, serial in 55:8, check byte in 63:56 |
| fn_tx_en | input | 1 | Function layer wants the next slot to return a bit |
| fn_tx_bit | input | 1 | Bit returned in that slot |
| line_pull | output | 1 | Pull-down enable for the open-drain line driver |
| rx_byte | output | 8 | Last byte received in the function phase |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| tx_ack | output | 1 | One-cycle strobe after a returned bit was sampled |
| rom_done | output | 1 | Addressing finished; function phase active |

## Verification
Each change on the line reaches the slot logic two synchroniser cycles plus the filter length later. Because of that delay and the tick phase, every timed line event can land up to about 1.5 µs late. The bench therefore samples the raw line in the middle of each window: presence at 8 µs or 60 µs after release, and returned bits at 3 µs or 15 µs after the fall. Slot-end release is checked at the last moment of the slot. `rom_done`, `rx_valid` and `tx_ack` are registered one cycle after the slot's sample point, so the bench reads them only at slot ends, well after that cycle. A monitor compares each `rx_valid` strobe against a queue of expected bytes on the falling clock edge.

// File: rtl/ow_pkg.sv
package ow_pkg;

  localparam int TW = 9;

  typedef enum logic [2:0] {E_IDLE, E_SLOT, E_PWAIT, E_PDRV, E_PREL} eng_st_t;
  typedef enum logic [2:0] {R_DEAD, R_CMD, R_RDROM, R_MATCH, R_SRCH, R_FUNC} rom_st_t;
  typedef enum logic [2:0] {T_RST, T_PWAIT, T_PDRV, T_SAMP, T_HOLD} tkind_t;

  localparam logic [7:0] OP_READ     = 8'h33;
  localparam logic [7:0] OP_READ_ALT = 8'h39;
  localparam logic [7:0] OP_MATCH    = 8'h55;
  localparam logic [7:0] OP_SKIP     = 8'hCC;
  localparam logic [7:0] OP_SEARCH   = 8'hF0;
  localparam logic [7:0] OP_RESUME   = 8'hA5;

  // Microsecond limits for each timed event, per speed profile.
  function automatic logic [TW-1:0] slot_us(input logic od, input tkind_t k);
    case (k)
      T_RST:   return od ? TW'(16) : TW'(120);
      T_PWAIT: return od ? TW'(2)  : TW'(20);
      T_PDRV:  return od ? TW'(10) : TW'(100);
      T_SAMP:  return od ? TW'(3)  : TW'(30);
      default: return od ? TW'(4)  : TW'(40);
    endcase
  endfunction

  // Decode of the address-layer command byte.
  function automatic rom_st_t op_next(input logic [7:0] op, input logic alt,
                                      input logic resume);
    if (op == (alt ? OP_READ_ALT : OP_READ)) return R_RDROM;
    case (op)
      OP_MATCH:  return R_MATCH;
      OP_SKIP:   return R_FUNC;
      OP_SEARCH: return R_SRCH;
      OP_RESUME: return resume ? R_FUNC : R_DEAD;
      default:   return R_DEAD;
    endcase
  endfunction

endpackage

// File: rtl/ow_line_filter.sv
module ow_line_filter #(
  parameter int FILT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_q,
  output logic fall,
  output logic rise
);
  localparam int RW = $clog2(FILT) + 1;

  logic [1:0]    sync;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      line_q <= 1'b1;
      run    <= '0;
      fall   <= 1'b0;
      rise   <= 1'b0;
    end else begin
      sync <= {sync[0], line_raw};
      fall <= 1'b0;
      rise <= 1'b0;
      if (sync[1] == line_q) begin
        run <= '0;
      end else if (run == RW'(FILT - 1)) begin
        line_q <= sync[1];
        run    <= '0;
        fall   <= line_q;
        rise   <= ~line_q;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = $clog2(CLK_PER_US) + 1;

  logic [DW-1:0] div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div  <= '0;
      tick <= 1'b0;
    end else if (div == DW'(CLK_PER_US - 1)) begin
      div  <= '0;
      tick <= 1'b1;
    end else begin
      div  <= div + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_q,
  input  logic fall,
  input  logic rise,
  input  logic speed_sel,
  input  logic rd_en,
  input  logic rd_bit,
  output logic drive_low,
  output logic bus_rst,
  output logic bit_done,
  output logic bit_val,
  output logic slot_rd
);
  eng_st_t       st;
  logic          od_q, rst_seen, sampled;
  logic [TW-1:0] cnt, low_us;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      od_q      <= 1'b0;
      rst_seen  <= 1'b0;
      sampled   <= 1'b0;
      cnt       <= '0;
      low_us    <= '0;
      drive_low <= 1'b0;
      bus_rst   <= 1'b0;
      bit_done  <= 1'b0;
      bit_val   <= 1'b0;
      slot_rd   <= 1'b0;
    end else begin
      bus_rst  <= 1'b0;
      bit_done <= 1'b0;
      // length of the present low period, independent of slot state
      if (line_q) low_us <= '0;
      else if (tick && low_us != {TW{1'b1}}) low_us <= low_us + 1'b1;
      if (!line_q && low_us >= slot_us(od_q, T_RST)) rst_seen <= 1'b1;
      if (tick && cnt != {TW{1'b1}}) cnt <= cnt + 1'b1;

      if (rise && rst_seen) begin
        rst_seen  <= 1'b0;
        bus_rst   <= 1'b1;
        drive_low <= 1'b0;
        cnt       <= '0;
        st        <= E_PWAIT;
      end else begin
        case (st)
          E_IDLE: if (fall) begin
            od_q      <= speed_sel;
            cnt       <= '0;
            sampled   <= 1'b0;
            slot_rd   <= rd_en;
            drive_low <= rd_en & ~rd_bit;
            st        <= E_SLOT;
          end
          E_SLOT: begin
            if (!sampled && cnt >= slot_us(od_q, T_SAMP)) begin
              sampled  <= 1'b1;
              bit_done <= 1'b1;
              bit_val  <= line_q;
            end
            if (cnt >= slot_us(od_q, T_HOLD)) begin
              drive_low <= 1'b0;
              if (sampled && line_q) st <= E_IDLE;
            end
          end
          E_PWAIT: if (cnt >= slot_us(od_q, T_PWAIT)) begin
            cnt       <= '0;
            drive_low <= 1'b1;
            st        <= E_PDRV;
          end
          E_PDRV: if (cnt >= slot_us(od_q, T_PDRV)) begin
            drive_low <= 1'b0;
            st        <= E_PREL;
          end
          E_PREL: if (line_q) st <= E_IDLE;
          default: st <= E_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_rom_ctrl.sv
module ow_rom_ctrl
  import ow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rst,
  input  logic        bit_done,
  input  logic        bit_val,
  input  logic        slot_rd,
  input  logic [63:0] dev_addr,
  input  logic        alt_read_op,
  input  logic        fn_tx_en,
  input  logic        fn_tx_bit,
  output logic        rd_en,
  output logic        rd_bit,
  output logic [7:0]  rx_byte,
  output logic        rx_valid,
  output logic        tx_ack,
  output logic        rom_done
);
  rom_st_t    st;
  logic [5:0] idx;
  logic [1:0] sub;
  logic [6:0] sh;
  logic       resume_q;

  wire [7:0] byte_in = {bit_val, sh};
  wire       own_bit = dev_addr[idx];

  assign rom_done = (st == R_FUNC);

  always_comb begin
    rd_en  = 1'b0;
    rd_bit = 1'b1;
    case (st)
      R_RDROM: begin rd_en = 1'b1; rd_bit = own_bit; end
      R_SRCH: if (sub != 2'd2) begin rd_en = 1'b1; rd_bit = own_bit ^ sub[0]; end
      R_FUNC:  begin rd_en = fn_tx_en; rd_bit = fn_tx_bit; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= R_DEAD;
      idx      <= '0;
      sub      <= '0;
      sh       <= '0;
      resume_q <= 1'b0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      tx_ack   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_ack   <= 1'b0;
      if (bus_rst) begin
        st  <= R_CMD;
        idx <= '0;
        sub <= '0;
      end else if (bit_done) begin
        case (st)
          R_CMD: begin
            sh  <= byte_in[7:1];
            idx <= idx + 6'd1;
            if (idx == 6'd7) begin
              idx <= '0;
              st  <= op_next(byte_in, alt_read_op, resume_q);
            end
          end
          R_RDROM: begin
            idx <= idx + 6'd1;
            if (idx == 6'd63) st <= R_FUNC;
          end
          R_MATCH: begin
            if (bit_val != own_bit) begin
              st       <= R_DEAD;
              resume_q <= 1'b0;
            end else if (idx == 6'd63) begin
              idx      <= '0;
              st       <= R_FUNC;
              resume_q <= 1'b1;
            end else begin
              idx <= idx + 6'd1;
            end
          end
          R_SRCH: begin
            if (sub != 2'd2) begin
              sub <= sub + 2'd1;
            end else begin
              sub <= '0;
              if (bit_val != own_bit) begin
                st       <= R_DEAD;
                resume_q <= 1'b0;
              end else if (idx == 6'd63) begin
                idx      <= '0;
                st       <= R_FUNC;
                resume_q <= 1'b1;
              end else begin
                idx <= idx + 6'd1;
              end
            end
          end
          R_FUNC: begin
            if (slot_rd) begin
              tx_ack <= 1'b1;
            end else begin
              sh  <= byte_in[7:1];
              idx <= idx + 6'd1;
              if (idx[2:0] == 3'd7) begin
                idx      <= '0;
                rx_byte  <= byte_in;
                rx_valid <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ow_rom_slave.sv
module ow_rom_slave #(
  parameter int CLK_PER_US = 50,
  parameter int FILT       = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_in,
  input  logic        speed_sel,
  input  logic        alt_read_op,
  input  logic [63:0] dev_addr,
  input  logic        fn_tx_en,
  input  logic        fn_tx_bit,
  output logic        line_pull,
  output logic [7:0]  rx_byte,
  output logic        rx_valid,
  output logic        tx_ack,
  output logic        rom_done
);
  // named internal events, also observed by the bound checker
  logic tick, line_q, fall, rise;
  logic bus_rst, bit_done, bit_val, slot_rd;
  logic rd_en, rd_bit;

  ow_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  ow_line_filter #(.FILT(FILT)) u_filt (
    .clk(clk), .rst_n(rst_n), .line_raw(line_in),
    .line_q(line_q), .fall(fall), .rise(rise));

  ow_slot_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_q(line_q),
    .fall(fall), .rise(rise), .speed_sel(speed_sel),
    .rd_en(rd_en), .rd_bit(rd_bit), .drive_low(line_pull),
    .bus_rst(bus_rst), .bit_done(bit_done), .bit_val(bit_val),
    .slot_rd(slot_rd));

  ow_rom_ctrl u_rom (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bit_done(bit_done),
    .bit_val(bit_val), .slot_rd(slot_rd), .dev_addr(dev_addr),
    .alt_read_op(alt_read_op), .fn_tx_en(fn_tx_en), .fn_tx_bit(fn_tx_bit),
    .rd_en(rd_en), .rd_bit(rd_bit), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .tx_ack(tx_ack), .rom_done(rom_done));
endmodule

// File: rtl/ow_rom_slave_chk.sv
module ow_rom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic line_pull,
  input logic rom_done,
  input logic rx_valid,
  input logic tx_ack,
  input logic bus_rst,
  input logic bit_done,
  input logic slot_rd
);
  // R2
  pres_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !line_pull);

  // R1
  rst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !rom_done);

  // R11
  rx_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_done));

  // R11
  ack_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> $past(bit_done && slot_rd));

  // R11
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, tx_ack}));

  // R12
  rx_needs_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rom_done));
endmodule

bind ow_rom_slave ow_rom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_pull(line_pull), .rom_done(rom_done),
  .rx_valid(rx_valid), .tx_ack(tx_ack), .bus_rst(bus_rst),
  .bit_done(bit_done), .slot_rd(slot_rd));

// File: tb/tb_ow_rom_slave.sv
`timescale 1ns/1ps
module tb_ow_rom_slave;
  localparam int CPU = 4;
  localparam logic [63:0] ADDR = 64'hA700_0012_3456_7832;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic speed_sel = 1'b0;
  logic alt_read_op = 1'b0;
  logic fn_tx_en = 1'b0;
  logic fn_tx_bit = 1'b1;
  logic line_pull, rx_valid, tx_ack, rom_done;
  logic [7:0] rx_byte;
  wire bus_w = ~(m_low | line_pull);

  int total = 0, bad = 0, ack_n = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  ow_rom_slave #(.CLK_PER_US(CPU), .FILT(2)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(bus_w), .speed_sel(speed_sel),
    .alt_read_op(alt_read_op), .dev_addr(ADDR), .fn_tx_en(fn_tx_en),
    .fn_tx_bit(fn_tx_bit), .line_pull(line_pull), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .tx_ack(tx_ack), .rom_done(rom_done));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_us(int n);
    repeat (n * CPU) @(posedge clk);
    #1;
  endtask

  // byte monitor: every strobe must match the next expected byte (R11, R3)
  always @(negedge clk) begin
    if (rx_valid) begin
      if (exp_q.size() == 0) check("R11 unexpected byte", {56'd0, rx_byte}, 64'hFFFF);
      else check("R3 R11 received byte", {56'd0, rx_byte}, {56'd0, exp_q.pop_front()});
    end
    if (tx_ack) ack_n++;
  end

  task automatic m_reset(bit od, int len, bit pres);
    speed_sel = od;
    wait_us(2);
    m_low = 1'b1; wait_us(len); m_low = 1'b0;
    wait_us(od ? 1 : 10);  check("R2 released before presence", bus_w, 1);
    wait_us(od ? 7 : 50);  check("R2 R5 presence low", bus_w, pres ? 0 : 1);
    wait_us(od ? 12 : 140); check("R2 presence ended", bus_w, 1);
  endtask

  task automatic write_bit(bit od, bit b);
    int lo = b ? (od ? 1 : 6) : (od ? 8 : 70);
    m_low = 1'b1; wait_us(lo); m_low = 1'b0;
    wait_us((od ? 12 : 90) - lo);
  endtask

  task automatic read_bit(bit od, output bit b);
    m_low = 1'b1; wait_us(od ? 1 : 5); m_low = 1'b0;
    wait_us(od ? 2 : 10); b = bus_w;
    wait_us(od ? 7 : 55);
    check("R4 line released at slot end", bus_w, 1);
  endtask

  task automatic send_byte(bit od, logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(od, v[i]);
  endtask

  task automatic read_addr(bit od, output logic [63:0] v);
    bit b;
    for (int i = 0; i < 64; i++) begin read_bit(od, b); v[i] = b; end
  endtask

  initial begin
    logic [63:0] got, m_addr;
    bit b, a0, a1;
    int errs;
    repeat (10) @(posedge clk);
    #1;
    check("R12 reset: line released", line_pull, 0);
    check("R12 reset: not addressed", rom_done, 0);
    rst_n = 1'b1;
    wait_us(5);

    // standard speed reset and read-address
    m_reset(0, 480, 1);
    check("R1 command phase after reset", rom_done, 0);
    send_byte(0, 8'h33);
    read_addr(0, got);
    check("R6 standard read-address", got, ADDR);
    check("R6 function phase", rom_done, 1);

    // reset aborts the function phase
    m_reset(1, 50, 1);
    check("R1 reset aborts function phase", rom_done, 0);

    // speed select decides what a 20 us low means
    m_reset(0, 20, 0);
    m_reset(1, 20, 1);

    // alternate read-address opcode
    alt_read_op = 1'b1;
    send_byte(1, 8'h39);
    read_addr(1, got);
    check("R6 alternate read-address", got, ADDR);
    m_reset(1, 50, 1);
    send_byte(1, 8'h33);
    read_bit(1, b);
    check("R12 unknown opcode: no pull", b, 1);
    send_byte(1, 8'h55);
    check("R12 unknown opcode: not addressed", rom_done, 0);
    alt_read_op = 1'b0;

    // match, then function traffic both ways
    m_reset(1, 50, 1);
    send_byte(1, 8'h55);
    for (int i = 0; i < 64; i++) write_bit(1, ADDR[i]);
    check("R7 match selects", rom_done, 1);
    exp_q.push_back(8'hA5); exp_q.push_back(8'h3C);
    send_byte(1, 8'hA5); send_byte(1, 8'h3C);
    fn_tx_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [3:0] pat = 4'b0110;
      fn_tx_bit = pat[i];
      read_bit(1, b);
      check("R11 returned function bit", b, pat[i]);
    end
    fn_tx_en = 1'b0;
    check("R11 tx acknowledges", ack_n, 4);

    m_reset(1, 50, 1);
    send_byte(1, 8'hA5);
    check("R10 resume after match", rom_done, 1);

    // match with one wrong bit
    m_reset(1, 50, 1);
    send_byte(1, 8'h55);
    m_addr = ADDR ^ 64'h400;
    for (int i = 0; i < 64; i++) write_bit(1, m_addr[i]);
    check("R7 mismatch not selected", rom_done, 0);
    send_byte(1, 8'h77);
    read_bit(1, b);
    check("R7 mismatch: no pull", b, 1);
    m_reset(1, 50, 1);
    send_byte(1, 8'hA5);
    check("R10 resume cleared by mismatch", rom_done, 0);

    // skip
    m_reset(1, 50, 1);
    send_byte(1, 8'hCC);
    check("R8 skip selects", rom_done, 1);
    exp_q.push_back(8'h5A);
    send_byte(1, 8'h5A);

    // full search
    m_reset(1, 50, 1);
    send_byte(1, 8'hF0);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      read_bit(1, a0); read_bit(1, a1);
      if (a0 != ADDR[i] || a1 != !ADDR[i]) errs++;
      write_bit(1, ADDR[i]);
    end
    check("R9 search bit pairs", errs, 0);
    check("R9 search selects", rom_done, 1);
    m_reset(1, 50, 1);
    send_byte(1, 8'hA5);
    check("R10 resume after search", rom_done, 1);

    // search dropout on the first bit
    m_reset(1, 50, 1);
    send_byte(1, 8'hF0);
    read_bit(1, a0); read_bit(1, a1);
    check("R9 first pair", {a0, a1}, {ADDR[0], !ADDR[0]});
    write_bit(1, !ADDR[0]);
    read_bit(1, b);
    check("R9 dropout: no pull", b, 1);
    check("R9 dropout: not selected", rom_done, 0);
    m_reset(1, 50, 1);
    send_byte(1, 8'hA5);
    check("R10 resume cleared by dropout", rom_done, 0);

    wait_us(5);
    check("R11 all expected bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule